// File: doc/BRIEF.md
# Tick-Locked Time Marker

This block divides the sample clock into a periodic tick strobe and derives from that strobe a marker output whose rising edges only ever happen in a tick cycle. A free-running counter sets the tick period. Software can retard or advance the tick phase without touching the normal period: it writes a one-time period value, the block uses that value for exactly one tick interval, and then it goes back to the normal period on its own.

The marker works in one of two modes. In single-shot mode, software sets an arm bit. The next tick raises the marker, and the hardware clears the arm bit in that same cycle. In divided mode, the marker rises on every N-th tick, where N is programmable. After each rise the marker stays high for a fixed number of sample clocks. It cannot start again while it is still high.

Software reaches the block through a small write port and a combinational read port, with four registers selected by a 2-bit address.

Top module: `tmk_timemark`

## Requirements
- R1: `tic` is high for one cycle out of every P cycles, where P is the period register (address 0). A period value of 0 behaves as 1, which means a tick on every cycle.
- R2: A write to the slew register (address 1) does not change the tick interval already running. The interval after it lasts the slew value. Every later interval uses the normal period again.
- R3: The slew-busy flag is control bit 2 (address 2). It reads 1 from the cycle after the slew write until the last cycle of the slewed interval. It reads 0 from the cycle after that.
- R4: Every rising edge of `tmark` falls in a cycle where `tic` is high.
- R5: Single-shot mode is control bit 1 = 0. When the arm bit (control bit 0) is set, the next tick raises `tmark` and clears the arm bit. A later tick raises nothing until software sets the arm bit again.
- R6: An arm write in a tick cycle raises no marker on that tick. It raises the marker on the following tick.
- R7: Divided mode is control bit 1 = 1, with divide count N at address 3. `tmark` rises on every N-th tick, so rises are P·N cycles apart and N−1 ticks fall strictly between them.
- R8: In divided mode with N = 0, `tmark` stays low.
- R9: After a rise, `tmark` stays high for exactly MARK_LEN cycles. A tick during that window starts no new pulse.
- R10: After reset, the period and slew registers read DEF_PERIOD and the control and divide registers read 0. `tmark` is low, and the first tick comes in the DEF_PERIOD-th cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select (0 period, 1 slew, 2 control, 3 divide) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | DATA_W | Read data, combinational |
| tic | output | 1 | Tick strobe, one cycle wide |
| tmark | output | 1 | Time marker, rises only on a tick |

## Verification
On every cycle, the assertions check four things. The marker rises only on a tick. The slewed interval begins only on a tick and ends after one interval. A fired single-shot clears its arm bit. The hold counter only counts down while the marker is held, so there is no retrigger. The bench is needed for the exact spacing between ticks and between marks for several period and divide pairs, the three-interval slew sequence, the timing of the busy flag, and the arm write that coincides with a tick. It also covers the zero period and zero divide cases and the register values after reset.

// File: rtl/tmk_pkg.sv
package tmk_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_PERIOD = 2'd0,
        SEL_SLEW   = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_DIV    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_EVERY_N = 1'b1
    } mark_mode_e;

    localparam int unsigned CTRL_ARM_BIT  = 0;
    localparam int unsigned CTRL_MODE_BIT = 1;
    localparam int unsigned CTRL_SLEW_BIT = 2;
endpackage

// File: rtl/tmk_regs.sv
module tmk_regs
    import tmk_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PER_W      = 16,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned DEF_PERIOD = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  arm,
    input  logic                  slew_busy,
    output logic [PER_W-1:0]      period,
    output logic [PER_W-1:0]      slew_period,
    output logic                  slew_req,
    output mark_mode_e            mode,
    output logic [DIV_W-1:0]      div_n,
    output logic                  arm_wr,
    output logic                  arm_wr_val
);
    localparam logic [PER_W-1:0] RST_PERIOD = PER_W'(DEF_PERIOD);

    reg_sel_e wsel;
    reg_sel_e rsel;

    always_comb begin
        wsel       = reg_sel_e'(wr_addr);
        rsel       = reg_sel_e'(rd_addr);
        slew_req   = wr_en && (wsel == SEL_SLEW);
        arm_wr     = wr_en && (wsel == SEL_CTRL);
        arm_wr_val = wr_data[CTRL_ARM_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period      <= RST_PERIOD;
            slew_period <= RST_PERIOD;
            mode        <= MODE_ONESHOT;
            div_n       <= '0;
        end else if (wr_en) begin
            case (wsel)
                SEL_PERIOD: period      <= wr_data[PER_W-1:0];
                SEL_SLEW:   slew_period <= wr_data[PER_W-1:0];
                SEL_CTRL:   mode        <= mark_mode_e'(wr_data[CTRL_MODE_BIT]);
                SEL_DIV:    div_n       <= wr_data[DIV_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_PERIOD: rd_data = DATA_W'(period);
            SEL_SLEW:   rd_data = DATA_W'(slew_period);
            SEL_CTRL: begin
                rd_data[CTRL_ARM_BIT]  = arm;
                rd_data[CTRL_MODE_BIT] = mode;
                rd_data[CTRL_SLEW_BIT] = slew_busy;
            end
            SEL_DIV:    rd_data = DATA_W'(div_n);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmk_tic_gen.sv
module tmk_tic_gen #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] slew_period,
    input  logic             slew_req,
    output logic             tic,
    output logic             slew_busy
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] lim_raw;
    logic [PER_W-1:0] lim;
    logic             slew_pend;
    logic             slew_act;

    always_comb begin
        lim_raw   = slew_act ? slew_period : period;
        lim       = (lim_raw == '0) ? PER_W'(1) : lim_raw;
        tic       = (cnt >= (lim - PER_W'(1)));
        slew_busy = slew_pend || slew_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            slew_pend <= 1'b0;
            slew_act  <= 1'b0;
        end else begin
            cnt <= tic ? '0 : cnt + PER_W'(1);
            if (tic) begin
                slew_act <= slew_pend;
            end
            if (slew_req) begin
                slew_pend <= 1'b1;
            end else if (tic) begin
                slew_pend <= 1'b0;
            end
        end
    end

    // R2: a slewed interval can only begin right after a tick
    a_r2_slew_starts_on_tic: assert property (@(posedge clk) disable iff (rst)
        $rose(slew_act) |-> $past(tic));

    // R2: with nothing queued, a slewed interval lasts one interval only
    a_r2_slew_one_interval: assert property (@(posedge clk) disable iff (rst)
        (tic && slew_act && !slew_pend) |=> !slew_act);
endmodule

// File: rtl/tmk_mark_gen.sv
module tmk_mark_gen
    import tmk_pkg::*;
#(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned MARK_LEN = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tic,
    input  mark_mode_e       mode,
    input  logic [DIV_W-1:0] div_n,
    input  logic             arm_wr,
    input  logic             arm_wr_val,
    output logic             arm,
    output logic             mark
);
    logic [DIV_W-1:0] div_cnt;
    logic             every_n;
    logic             div_live;
    logic             per_due;
    logic             shot_due;
    logic             busy;
    logic             fire;

    always_comb begin
        every_n  = (mode == MODE_EVERY_N);
        div_live = every_n && (div_n != '0);
        per_due  = div_live && tic && (div_cnt >= (div_n - DIV_W'(1)));
        shot_due = !every_n && tic && arm;
        fire     = (per_due || shot_due) && !busy;
        mark     = fire || busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (!div_live) begin
            div_cnt <= '0;
        end else if (tic) begin
            div_cnt <= per_due ? '0 : div_cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm <= 1'b0;
        end else if (arm_wr) begin
            arm <= arm_wr_val;
        end else if (shot_due && !busy) begin
            arm <= 1'b0;
        end
    end

    generate
        if (MARK_LEN <= 1) begin : g_short
            assign busy = 1'b0;
        end else begin : g_hold
            localparam int unsigned HOLD_W = $clog2(MARK_LEN);
            logic [HOLD_W-1:0] hold_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= '0;
                end else if (fire) begin
                    hold_q <= HOLD_W'(MARK_LEN - 1);
                end else if (hold_q != '0) begin
                    hold_q <= hold_q - HOLD_W'(1);
                end
            end
            assign busy = (hold_q != '0);

            // R9: while held, the hold only counts down and is never reloaded
            a_r9_no_retrigger: assert property (@(posedge clk) disable iff (rst)
                busy |=> (hold_q == $past(hold_q) - HOLD_W'(1)));
        end
    endgenerate

    // R4: marker edges are locked to ticks
    a_r4_rise_on_tic: assert property (@(posedge clk) disable iff (rst)
        $rose(mark) |-> tic);

    // R5: a fired single-shot clears the arm bit
    a_r5_arm_clears: assert property (@(posedge clk) disable iff (rst)
        (tic && arm && !every_n && !busy && !arm_wr) |=> !arm);

    // R8: zero divide count keeps the marker silent
    a_r8_zero_div_quiet: assert property (@(posedge clk) disable iff (rst)
        (every_n && (div_n == '0) && !busy) |-> !mark);
endmodule

// File: rtl/tmk_timemark.sv
module tmk_timemark
    import tmk_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PER_W      = 16,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned DEF_PERIOD = 10,
    parameter int unsigned MARK_LEN   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tic,
    output logic              tmark
);
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] slew_period;
    logic             slew_req;
    logic             slew_busy;
    mark_mode_e       mode;
    logic [DIV_W-1:0] div_n;
    logic             arm_wr;
    logic             arm_wr_val;
    logic             arm;

    tmk_regs #(
        .DATA_W    (DATA_W),
        .PER_W     (PER_W),
        .DIV_W     (DIV_W),
        .DEF_PERIOD(DEF_PERIOD)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .arm        (arm),
        .slew_busy  (slew_busy),
        .period     (period),
        .slew_period(slew_period),
        .slew_req   (slew_req),
        .mode       (mode),
        .div_n      (div_n),
        .arm_wr     (arm_wr),
        .arm_wr_val (arm_wr_val)
    );

    tmk_tic_gen #(
        .PER_W(PER_W)
    ) u_tic (
        .clk        (clk),
        .rst        (rst),
        .period     (period),
        .slew_period(slew_period),
        .slew_req   (slew_req),
        .tic        (tic),
        .slew_busy  (slew_busy)
    );

    tmk_mark_gen #(
        .DIV_W   (DIV_W),
        .MARK_LEN(MARK_LEN)
    ) u_mark (
        .clk       (clk),
        .rst       (rst),
        .tic       (tic),
        .mode      (mode),
        .div_n     (div_n),
        .arm_wr    (arm_wr),
        .arm_wr_val(arm_wr_val),
        .arm       (arm),
        .mark      (tmark)
    );
endmodule

// File: tb/tmk_timemark_bench.sv
module tmk_timemark_bench;
    localparam int DEF_P = 10;
    localparam int MLEN  = 3;
    localparam int NVEC  = 5;
    localparam int VEC [NVEC][2] = '{'{4, 1}, '{3, 2}, '{5, 3}, '{2, 3}, '{6, 2}};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tic;
    logic        tmark;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    tmk_timemark #(.DEF_PERIOD(DEF_P), .MARK_LEN(MLEN)) u_tmk_timemark (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tic(tic), .tmark(tmark)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // caller is at a negedge; write is captured at the next posedge
    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        rd_addr = 2'(addr);
        #1;
        data = int'(rd_data);
    endtask

    task automatic wait_tic();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!tic && g < 5000);
    endtask

    task automatic wait_rise();
        bit prev;
        int g = 0;
        prev = tmark;
        do begin
            @(negedge clk);
            g++;
            if (tmark && !prev) break;
            prev = tmark;
        end while (g < 5000);
    endtask

    // precondition: at the negedge where tmark just rose
    task automatic measure(output int len, output int gap, output int tics);
        int c0 = cyc;
        int g = 0;
        len = 1; tics = 0;
        @(negedge clk);
        while (tmark && g < 5000) begin
            if (tic) tics++;
            len++; g++;
            @(negedge clk);
        end
        while (!tmark && g < 5000) begin
            if (tic) tics++;
            g++;
            @(negedge clk);
        end
        gap = cyc - c0;
    endtask

    initial begin : wdog
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int v, c0, len, gap, tics;

        // R10: reset values and first tick position
        do_reset();
        c0 = cyc;
        rd(0, v); chk("R10 period reset", v, DEF_P);
        rd(1, v); chk("R10 slew reset", v, DEF_P);
        rd(2, v); chk("R10 ctrl reset", v, 0);
        rd(3, v); chk("R10 divide reset", v, 0);
        chk("R10 tmark low", int'(tmark), 0);
        wait_tic();
        chk("R10 first tick cycle", cyc - c0 + 1, DEF_P);
        wait_tic();
        chk("R1 tick spacing default", cyc - c0 + 1, 2 * DEF_P);

        // R7/R9/R4: vector table of period and divide pairs
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            wr(0, VEC[i][0]);
            wr(3, VEC[i][1]);
            wr(2, 2);
            wait_rise();
            wait_rise();
            chk("R4 rise on tick", int'(tic), 1);
            measure(len, gap, tics);
            chk("R7 mark spacing", gap, VEC[i][0] * VEC[i][1]);
            chk("R7 ticks between marks", tics, VEC[i][1] - 1);
            chk("R9 mark length", len, MLEN);
            chk("R4 rise on tick again", int'(tic), 1);
        end

        // R9: ticks during the hold window start no new pulse
        do_reset();
        wr(0, 2); wr(3, 1); wr(2, 2);
        wait_rise(); wait_rise();
        measure(len, gap, tics);
        chk("R9 hold length with tick inside", len, MLEN);
        chk("R9 no retrigger spacing", gap, 4);
        chk("R9 tick inside window seen", tics, 1);

        // R8: divided mode with zero count stays low
        do_reset();
        wr(0, 3); wr(3, 0); wr(2, 2);
        v = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tmark) v++;
        end
        chk("R8 zero divide marks", v, 0);

        // R1: zero period behaves as one
        do_reset();
        wr(0, 0);
        @(negedge clk);
        v = 0;
        for (int k = 0; k < 4; k++) begin
            if (tic) v++;
            @(negedge clk);
        end
        chk("R1 zero period ticks every cycle", v, 4);

        // R2/R3: single slewed interval
        do_reset();
        wr(0, 5);
        wait_tic(); wait_tic();
        c0 = cyc;
        wr(1, 8);
        rd(2, v); chk("R3 busy after write", (v >> 2) & 1, 1);
        wait_tic();
        chk("R2 running interval unchanged", cyc - c0, 5);
        c0 = cyc;
        wait_tic();
        chk("R2 slewed interval", cyc - c0, 8);
        rd(2, v); chk("R3 busy in last slewed cycle", (v >> 2) & 1, 1);
        c0 = cyc;
        @(negedge clk);
        rd(2, v); chk("R3 busy clears", (v >> 2) & 1, 0);
        wait_tic();
        chk("R2 reverts to normal", cyc - c0, 5);

        // R5: single-shot arm
        do_reset();
        wr(0, 6);
        wait_tic();
        @(negedge clk); @(negedge clk);
        wr(2, 1);
        rd(2, v); chk("R5 arm reads set", v & 1, 1);
        wait_tic();
        chk("R5 mark on next tick", int'(tmark), 1);
        @(negedge clk);
        rd(2, v); chk("R5 arm cleared", v & 1, 0);
        wait_tic();
        chk("R5 no mark without arm", int'(tmark), 0);

        // R6: arm written in a tick cycle
        wait_tic();
        chk("R6 no mark on write tick", int'(tmark), 0);
        wr(2, 1);
        wait_tic();
        chk("R6 mark on following tick", int'(tmark), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule